// File: doc/BRIEF.md
# Fetch group extractor

This block sits at the front of an instruction pipeline. It holds one thread's program counter and a single buffered instruction line, and each cycle it cuts a group of up to `FETCH_W` 32-bit instructions out of that line toward decode. When the line needed by the current PC is not buffered, it raises a line-fill request instead. While that request is outstanding, it fetches nothing.

A group runs from the word that holds the PC. It stops at the first of three points: the end of the line, the width limit, or a slot that the external predictor marks as taken. At the clock edge after a group is emitted, the PC moves to the predicted target, or else to the word after the last emitted instruction.

Two conditions change this normal flow. A translation fault on a needed fill becomes a single fault-carrying no-op, and the thread then parks in a trap-pending state. A pending interrupt holds fetching while the PC is word-aligned. A redirect loads a new PC, leaves the trap state and abandons any outstanding fill.

Top module: `fetch_group_extractor`

## Requirements
- R1: While running, a fill request is made only when the buffered line is invalid or its tag differs from the PC with its low log2(LINE_BYTES) bits cleared. `fillAddr` carries that aligned address. On a hit, `fillReq` stays 0.
- R2: A fill request clears the line's valid flag at the next edge, and no group is emitted while waiting. A response is accepted only while waiting; a response arriving at any other time leaves the buffered line unchanged. The group comes out in the cycle after the accepted response.
- R3: Slot k holds the line word at byte offset ((PC mod LINE_BYTES) with bits 1:0 cleared) + 4k, and its `slotPc` is (PC with bits 1:0 cleared) + 4k. Words are little-endian: line byte b sits at `fillData[8b+7:8b]`, and instruction bits 7:0 come from the lowest byte. Slot k occupies `slotInstr[32k+31:32k]`.
- R4: A group never crosses the line end: with no taken prediction, `groupCount` = min(FETCH_W, LINE_BYTES/4 − start word). Valid slots are always contiguous from slot 0.
- R5: `groupCount` never exceeds FETCH_W.
- R6: If emitted slot k has `predTaken[k]`=1, slots above k are invalid and the next PC is `predTarget[k]`. A taken flag on a slot that is not emitted has no effect.
- R7: With no emitted slot predicted taken, the next PC is (PC with bits 1:0 cleared) + 4·`groupCount`.
- R8: With `intPending`=1 and PC bits 1:0 equal to 00, there is no fill request and no group, and the PC holds. If PC bits 1:0 are nonzero, fetching proceeds despite `intPending`.
- R9: A needed fill with `fetchFault`=1 emits no fill request. Instead it emits exactly one slot (slot 0) holding `NOP_WORD` (default 0) with `groupFault`=1. From the next edge, `trapPending`=1, no group or fill is produced and the PC is kept, until a redirect.
- R10: `redirValid` loads `redirPc` at the edge, clears `trapPending` and abandons an outstanding fill. The abandoned fill leaves the line invalid, so the next miss requests the line again.
- R11: Reset sets the PC to `RESET_PC` (default 0), clears the line's valid flag and `trapPending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| redirValid | input | 1 | Load a new PC |
| redirPc | input | ADDR_W | PC to load |
| intPending | input | 1 | Interrupt pending |
| fetchFault | input | 1 | Translation fault for the needed line |
| predTaken | input | FETCH_W | Per-slot taken prediction |
| predTarget | input | FETCH_W*ADDR_W | Per-slot predicted target |
| fillValid | input | 1 | Fill response strobe |
| fillData | input | LINE_BYTES*8 | Fill response line |
| fillReq | output | 1 | Line fill request |
| fillAddr | output | ADDR_W | Aligned line address |
| slotValid | output | FETCH_W | Valid slots of the group |
| slotInstr | output | FETCH_W*32 | Slot instruction words |
| slotPc | output | FETCH_W*ADDR_W | Slot PCs |
| groupCount | output | $clog2(FETCH_W+1) | Number of valid slots |
| groupFault | output | 1 | Group is a fault no-op |
| trapPending | output | 1 | Thread waits for a redirect after a fault |
| pcOut | output | ADDR_W | Current PC |

## Verification
The group, its count, the fault flag and the fill request are combinational. They are due in the same cycle as the PC and inputs that produce them. The bench drives on the falling edge and samples these outputs 1 ns later. The PC, `trapPending` and the line's valid state change one edge later, so those checks wait for the next falling edge. The bench holds `intPending` high between tests so that the PC advances on exactly one chosen edge.

// File: rtl/fge_pkg.sv
package fge_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_TRAP = 2'd2
  } fgeState_e;

  typedef struct packed {
    logic redirect;
    logic extract;
    logic fill;
    logic trap;
    logic capture;
  } fgeStrobe_t;
endpackage

// File: rtl/fge_ctrl.sv
module fge_ctrl
  import fge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       redirValid,
  input  logic       intPending,
  input  logic       fetchFault,
  input  logic       fillValid,
  input  logic       lineHit,
  input  logic       pcLowZero,
  output fgeStrobe_t strb,
  output logic       trapPending
);
  fgeState_e stateQ, stateD;
  logic      active;

  always_comb begin
    active        = (stateQ == ST_RUN) && !redirValid && !(intPending && pcLowZero);
    strb.redirect = redirValid;
    strb.extract  = active && lineHit;
    strb.fill     = active && !lineHit && !fetchFault;
    strb.trap     = active && !lineHit && fetchFault;
    strb.capture  = (stateQ == ST_WAIT) && fillValid && !redirValid;
  end

  always_comb begin
    stateD = stateQ;
    if (redirValid)        stateD = ST_RUN;
    else if (strb.fill)    stateD = ST_WAIT;
    else if (strb.trap)    stateD = ST_TRAP;
    else if (strb.capture) stateD = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  assign trapPending = (stateQ == ST_TRAP);

  AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (trapPending && !redirValid) |=> trapPending);  // R9
  AST_REDIRECT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> !trapPending);  // R10
endmodule

// File: rtl/fge_datapath.sv
module fge_datapath
  import fge_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int FETCH_W    = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [31:0] NOP_WORD = 32'h0000_0000,
  localparam int LINE_WORDS = LINE_BYTES / 4,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int WIDX_W     = OFF_W - 2,
  localparam int CNT_W      = $clog2(FETCH_W + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fgeStrobe_t                  strb,
  input  logic [ADDR_W-1:0]           redirPc,
  input  logic [FETCH_W-1:0]          predTaken,
  input  logic [FETCH_W*ADDR_W-1:0]   predTarget,
  input  logic [LINE_BYTES*8-1:0]     fillData,
  output logic                        lineHit,
  output logic                        pcLowZero,
  output logic                        fillReq,
  output logic [ADDR_W-1:0]           fillAddr,
  output logic [FETCH_W-1:0]          slotValid,
  output logic [FETCH_W*32-1:0]       slotInstr,
  output logic [FETCH_W*ADDR_W-1:0]   slotPc,
  output logic [CNT_W-1:0]            groupCount,
  output logic                        groupFault,
  output logic [ADDR_W-1:0]           pcOut
);
  logic [ADDR_W-1:0]       pcQ;
  logic                    lineValidQ;
  logic [ADDR_W-1:0]       lineTagQ;
  logic [LINE_BYTES*8-1:0] lineDataQ;

  logic [ADDR_W-1:0]  alignedPc, pcBase, nextPcD, takenTarget;
  logic [WIDX_W-1:0]  startIdx;
  logic [FETCH_W-1:0] candValid;
  logic [CNT_W-1:0]   candCount;
  logic               takenHit, alive;

  assign alignedPc = {pcQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign pcBase    = {pcQ[ADDR_W-1:2], 2'b00};
  assign startIdx  = pcQ[OFF_W-1:2];
  assign lineHit   = lineValidQ && (lineTagQ == alignedPc);
  assign pcLowZero = (pcQ[1:0] == 2'b00);

  // group boundary: line end, width limit, first taken slot
  always_comb begin
    alive       = 1'b1;
    candValid   = '0;
    candCount   = '0;
    takenHit    = 1'b0;
    takenTarget = '0;
    for (int i = 0; i < FETCH_W; i++) begin
      if (alive && (int'(startIdx) + i < LINE_WORDS)) begin
        candValid[i] = 1'b1;
        candCount    = candCount + CNT_W'(1);
        if (predTaken[i]) begin
          takenHit    = 1'b1;
          takenTarget = predTarget[i*ADDR_W +: ADDR_W];
          alive       = 1'b0;
        end
      end else begin
        alive = 1'b0;
      end
    end
  end

  assign nextPcD = takenHit ? takenTarget : pcBase + ADDR_W'({candCount, 2'b00});

  for (genvar g = 0; g < FETCH_W; g++) begin : gSlot
    logic [WIDX_W-1:0] wordIdx;
    assign wordIdx = startIdx + WIDX_W'(g);
    assign slotPc[g*ADDR_W +: ADDR_W] = pcBase + ADDR_W'(4 * g);
    if (g == 0) begin : gFirst
      assign slotInstr[31:0] = strb.trap ? NOP_WORD : lineDataQ[{wordIdx, 5'd0} +: 32];
    end else begin : gRest
      assign slotInstr[g*32 +: 32] = lineDataQ[{wordIdx, 5'd0} +: 32];
    end
  end

  always_comb begin
    if (strb.extract) begin
      slotValid  = candValid;
      groupCount = candCount;
    end else if (strb.trap) begin
      slotValid  = FETCH_W'(1);
      groupCount = CNT_W'(1);
    end else begin
      slotValid  = '0;
      groupCount = '0;
    end
  end

  assign groupFault = strb.trap;
  assign fillReq    = strb.fill;
  assign fillAddr   = alignedPc;
  assign pcOut      = pcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= RESET_PC;
    end else if (strb.redirect) begin
      pcQ <= redirPc;
    end else if (strb.extract) begin
      pcQ <= nextPcD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValidQ <= 1'b0;
      lineTagQ   <= '0;
      lineDataQ  <= '0;
    end else if (strb.fill) begin
      lineValidQ <= 1'b0;
      lineTagQ   <= alignedPc;
    end else if (strb.capture) begin
      lineValidQ <= 1'b1;
      lineDataQ  <= fillData;
    end
  end

  AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !(lineValidQ && (lineTagQ == fillAddr)));  // R1
  AST_FILL_INVALIDATES: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |=> !lineValidQ);  // R2
  AST_SLOTS_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rstN)
    ((slotValid + FETCH_W'(1)) & slotValid) == '0);  // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    groupCount <= CNT_W'(FETCH_W));  // R5
  AST_TAKEN_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.extract && predTaken[0]) |-> (groupCount == CNT_W'(1)));  // R6
  AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    groupFault |-> (groupCount == CNT_W'(1)) && $onehot0(slotValid) && !fillReq);  // R9
endmodule

// File: rtl/fetch_group_extractor.sv
module fetch_group_extractor
  import fge_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int FETCH_W    = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [31:0] NOP_WORD = 32'h0000_0000,
  localparam int CNT_W = $clog2(FETCH_W + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      redirValid,
  input  logic [ADDR_W-1:0]         redirPc,
  input  logic                      intPending,
  input  logic                      fetchFault,
  input  logic [FETCH_W-1:0]        predTaken,
  input  logic [FETCH_W*ADDR_W-1:0] predTarget,
  input  logic                      fillValid,
  input  logic [LINE_BYTES*8-1:0]   fillData,
  output logic                      fillReq,
  output logic [ADDR_W-1:0]         fillAddr,
  output logic [FETCH_W-1:0]        slotValid,
  output logic [FETCH_W*32-1:0]     slotInstr,
  output logic [FETCH_W*ADDR_W-1:0] slotPc,
  output logic [CNT_W-1:0]          groupCount,
  output logic                      groupFault,
  output logic                      trapPending,
  output logic [ADDR_W-1:0]         pcOut
);
  fgeStrobe_t strb;
  logic       lineHit, pcLowZero;

  fge_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .redirValid (redirValid),
    .intPending (intPending),
    .fetchFault (fetchFault),
    .fillValid  (fillValid),
    .lineHit    (lineHit),
    .pcLowZero  (pcLowZero),
    .strb       (strb),
    .trapPending(trapPending)
  );

  fge_datapath #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .FETCH_W   (FETCH_W),
    .RESET_PC  (RESET_PC),
    .NOP_WORD  (NOP_WORD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .redirPc   (redirPc),
    .predTaken (predTaken),
    .predTarget(predTarget),
    .fillData  (fillData),
    .lineHit   (lineHit),
    .pcLowZero (pcLowZero),
    .fillReq   (fillReq),
    .fillAddr  (fillAddr),
    .slotValid (slotValid),
    .slotInstr (slotInstr),
    .slotPc    (slotPc),
    .groupCount(groupCount),
    .groupFault(groupFault),
    .pcOut     (pcOut)
  );

  AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (intPending && (pcOut[1:0] == 2'b00)) |-> (groupCount == '0) && !fillReq);  // R8
endmodule

// File: tb/sim_fetch_group_extractor.sv
module sim_fetch_group_extractor;
  localparam int ADDR_W = 32;
  localparam int LINE_BYTES = 32;
  localparam int FETCH_W = 4;
  localparam int CNT_W = $clog2(FETCH_W + 1);

  logic clk = 1'b0;
  logic rstN;
  logic redirValid;
  logic [ADDR_W-1:0] redirPc;
  logic intPending, fetchFault;
  logic [FETCH_W-1:0] predTaken;
  logic [FETCH_W*ADDR_W-1:0] predTarget;
  logic fillValid;
  logic [LINE_BYTES*8-1:0] fillData;
  logic fillReq;
  logic [ADDR_W-1:0] fillAddr;
  logic [FETCH_W-1:0] slotValid;
  logic [FETCH_W*32-1:0] slotInstr;
  logic [FETCH_W*ADDR_W-1:0] slotPc;
  logic [CNT_W-1:0] groupCount;
  logic groupFault, trapPending;
  logic [ADDR_W-1:0] pcOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fetch_group_extractor u0 (
    .clk(clk), .rstN(rstN), .redirValid(redirValid), .redirPc(redirPc),
    .intPending(intPending), .fetchFault(fetchFault), .predTaken(predTaken),
    .predTarget(predTarget), .fillValid(fillValid), .fillData(fillData),
    .fillReq(fillReq), .fillAddr(fillAddr), .slotValid(slotValid),
    .slotInstr(slotInstr), .slotPc(slotPc), .groupCount(groupCount),
    .groupFault(groupFault), .trapPending(trapPending), .pcOut(pcOut)
  );

  typedef struct packed {
    logic [3:0]  startWord;
    logic [3:0]  takenMask;
    logic [3:0]  expCount;
    logic [31:0] expNext;
  } vec_t;

  // predicted target of slot k is 0x2000 + 0x10*k; line lives at 0x1000
  localparam vec_t VECS [9] = '{
    '{4'd0, 4'b0000, 4'd4, 32'h1010},
    '{4'd2, 4'b0000, 4'd4, 32'h1018},
    '{4'd5, 4'b0000, 4'd3, 32'h1020},
    '{4'd7, 4'b0000, 4'd1, 32'h1020},
    '{4'd0, 4'b0010, 4'd2, 32'h2010},
    '{4'd0, 4'b0001, 4'd1, 32'h2000},
    '{4'd6, 4'b0100, 4'd2, 32'h1020},
    '{4'd4, 4'b1000, 4'd4, 32'h2030},
    '{4'd1, 4'b1010, 4'd2, 32'h2010}
  };

  function automatic logic [7:0] lineByte(int b);
    return 8'(b * 13 + 5);
  endfunction

  function automatic logic [LINE_BYTES*8-1:0] lineImage();
    logic [LINE_BYTES*8-1:0] img;
    for (int b = 0; b < LINE_BYTES; b++) img[b*8 +: 8] = lineByte(b);
    return img;
  endfunction

  function automatic logic [31:0] wordExp(int w);
    return {lineByte(4*w+3), lineByte(4*w+2), lineByte(4*w+1), lineByte(4*w)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; redirValid = 1'b0; redirPc = '0; intPending = 1'b1;
    fetchFault = 1'b0; predTaken = '0; fillValid = 1'b0; fillData = '0;
    for (int k = 0; k < FETCH_W; k++) predTarget[k*ADDR_W +: ADDR_W] = 32'h2000 + 32'(16*k);

    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset pc", 64'(pcOut), 64'h0);
    chk("R11 reset trap", 64'(trapPending), 64'h0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R8 hold no fill", 64'(fillReq), 64'h0);
    chk("R8 hold pc", 64'(pcOut), 64'h0);

    // first fill
    redirValid = 1'b1; redirPc = 32'h1004; intPending = 1'b0;
    @(negedge clk); redirValid = 1'b0; #1;
    chk("R1 miss request", 64'(fillReq), 64'h1);
    chk("R1 fill address", 64'(fillAddr), 64'h1000);
    chk("R2 no group on miss", 64'(groupCount), 64'h0);
    @(negedge clk); #1;
    chk("R2 waiting no request", 64'(fillReq), 64'h0);
    chk("R2 waiting no group", 64'(groupCount), 64'h0);
    fillValid = 1'b1; fillData = lineImage();
    @(negedge clk); fillValid = 1'b0; #1;
    chk("R2 group after response", 64'(groupCount), 64'h4);
    chk("R2 first word", 64'(slotInstr[31:0]), 64'(wordExp(1)));
    intPending = 1'b1;

    // stray response while not waiting: must be ignored
    @(negedge clk); fillValid = 1'b1; fillData = ~lineImage();
    @(negedge clk); fillValid = 1'b0;

    foreach (VECS[v]) begin
      redirValid = 1'b1; redirPc = 32'h1000 + 32'(4 * VECS[v].startWord);
      @(negedge clk);
      redirValid = 1'b0; intPending = 1'b0; predTaken = VECS[v].takenMask;
      #1;
      chk("R1 hit no request", 64'(fillReq), 64'h0);
      chk("R4 R5 R6 count", 64'(groupCount), 64'(VECS[v].expCount));
      for (int k = 0; k < FETCH_W; k++) begin
        if (k < int'(VECS[v].expCount)) begin
          chk("R3 slot valid", 64'(slotValid[k]), 64'h1);
          // R2: stray response earlier must not have changed these words
          chk("R3 slot word", 64'(slotInstr[k*32 +: 32]), 64'(wordExp(int'(VECS[v].startWord) + k)));
          chk("R3 slot pc", 64'(slotPc[k*ADDR_W +: ADDR_W]), 64'h1000 + 64'(4 * (int'(VECS[v].startWord) + k)));
        end else begin
          chk("R4 R6 slot invalid", 64'(slotValid[k]), 64'h0);
        end
      end
      @(negedge clk);
      intPending = 1'b1; predTaken = '0;
      #1;
      chk("R6 R7 next pc", 64'(pcOut), 64'(VECS[v].expNext));
    end

    // interrupt pending but PC low bits nonzero: fetch proceeds
    redirValid = 1'b1; redirPc = 32'h1002;
    @(negedge clk); redirValid = 1'b0; #1;
    chk("R8 unaligned fetches", 64'(groupCount), 64'h4);
    chk("R8 unaligned slot pc", 64'(slotPc[ADDR_W-1:0]), 64'h1000);
    chk("R8 unaligned word", 64'(slotInstr[31:0]), 64'(wordExp(0)));
    @(negedge clk); #1;
    chk("R8 unaligned next pc", 64'(pcOut), 64'h1010);
    @(negedge clk); #1;
    chk("R8 aligned hold pc", 64'(pcOut), 64'h1010);
    chk("R8 aligned hold group", 64'(groupCount), 64'h0);

    // fault on a needed fill
    redirValid = 1'b1; redirPc = 32'h3000;
    @(negedge clk); redirValid = 1'b0; intPending = 1'b0; fetchFault = 1'b1; #1;
    chk("R9 fault count", 64'(groupCount), 64'h1);
    chk("R9 fault slots", 64'(slotValid), 64'h1);
    chk("R9 fault nop", 64'(slotInstr[31:0]), 64'h0);
    chk("R9 fault flag", 64'(groupFault), 64'h1);
    chk("R9 fault no request", 64'(fillReq), 64'h0);
    @(negedge clk); fetchFault = 1'b0; #1;
    chk("R9 trap pending", 64'(trapPending), 64'h1);
    chk("R9 trap no group", 64'(groupCount), 64'h0);
    chk("R9 trap no request", 64'(fillReq), 64'h0);
    chk("R9 trap pc kept", 64'(pcOut), 64'h3000);
    @(negedge clk); #1;
    chk("R9 trap still pending", 64'(trapPending), 64'h1);

    // redirect leaves the trap
    intPending = 1'b1; redirValid = 1'b1; redirPc = 32'h1000;
    @(negedge clk); redirValid = 1'b0; #1;
    chk("R10 trap cleared", 64'(trapPending), 64'h0);
    intPending = 1'b0; #1;
    chk("R10 fetch resumes", 64'(groupCount), 64'h4);
    intPending = 1'b1;

    // redirect abandons an outstanding fill
    @(negedge clk); redirValid = 1'b1; redirPc = 32'h4000; intPending = 1'b0;
    @(negedge clk); redirValid = 1'b0; #1;
    chk("R10 new miss address", 64'(fillAddr), 64'h4000);
    @(negedge clk); redirValid = 1'b1; redirPc = 32'h1000;
    @(negedge clk); redirValid = 1'b0; #1;
    chk("R10 refetch request", 64'(fillReq), 64'h1);
    chk("R10 refetch address", 64'(fillAddr), 64'h1000);
    chk("R10 no group", 64'(groupCount), 64'h0);
    @(negedge clk); fillValid = 1'b1; fillData = lineImage();
    @(negedge clk); fillValid = 1'b0; #1;
    chk("R10 group after refill", 64'(groupCount), 64'h4);
    chk("R10 refill word", 64'(slotInstr[31:0]), 64'(wordExp(0)));
    intPending = 1'b1;
    @(negedge clk);
    finishRun();
  end
endmodule